// File: doc/BRIEF.md
# Exclusive Doubleword Load Unit

This unit carries out a load-exclusive of a register pair for a 32-bit core. A decoded request gives a base register value, the two destination register indices, a flag saying whether the instruction's condition passed, the current data endianness and the shared attribute of the target memory. The unit uses the base value as the address with no offset. It checks that the address is 8-byte aligned and issues a single 64-bit read. When the read data comes back, it returns both 32-bit words to the register file together.

In the cycle the read is accepted by memory, the unit also arms the core's local exclusive monitor with the address and an 8-byte access size. If the memory is shared, it raises a mark request toward the global exclusive monitor in that same cycle. A request whose condition failed is consumed with no effect. A misaligned address produces a one-cycle alignment fault, and no read is issued.

Top module: `ldxPairUnit`

## Requirements
- R1: The memory read address `memReqAddr` equals the request's `reqBase` exactly, and it stays constant while the read is pending.
- R2: Each accepted request with `reqCondPass`=1 and an aligned base issues exactly one 64-bit read. `memReqValid` stays high until the cycle in which `memReqReady` is high, and drops after that cycle.
- R3: With `reqBigEndian`=0, `wbDataA` (for index `reqDstA`) carries bits 31:0 of the read data, and `wbDataB` (for index `reqDstB`) carries bits 63:32.
- R4: With `reqBigEndian`=1, the halves are swapped: `wbDataA` carries bits 63:32 and `wbDataB` carries bits 31:0.
- R5: In the read handshake cycle, `monArm` pulses once, with `monAddr` equal to the base and `monSize` equal to 8.
- R6: `globalMark` pulses once in the read handshake cycle with `globalMarkAddr` equal to the base when `reqShared`=1. It never pulses for a request with `reqShared`=0.
- R7: A request accepted with `reqCondPass`=0 has no effect, even when its address is misaligned. It produces no read, no writeback, no monitor arm, no global mark and no fault, and the unit is ready again in the next cycle.
- R8: A request accepted with `reqCondPass`=1 and base bits 2:0 not all zero raises `alignFault` for exactly one cycle, the cycle after acceptance. It issues no read, arms no monitor and produces no writeback.
- R9: `reqReady` is high only while the unit is idle. A request presented while the unit is busy is ignored and does not change the pending address.
- R10: `wbValid` is a single-cycle pulse. It is high in the cycle right after the `memRspValid` cycle, whatever the data value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle, request taken this cycle |
| reqBase | input | 32 | Base register value (address) |
| reqDstA | input | 4 | Index of the register loaded from the address |
| reqDstB | input | 4 | Index of the register loaded from address+4 |
| reqCondPass | input | 1 | Condition check passed |
| reqBigEndian | input | 1 | Data endianness is big |
| reqShared | input | 1 | Target memory is shared |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Doubleword read address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data |
| wbValid | output | 1 | Both writebacks valid (done pulse) |
| wbIdxA | output | 4 | First destination index |
| wbDataA | output | 32 | First destination data |
| wbIdxB | output | 4 | Second destination index |
| wbDataB | output | 32 | Second destination data |
| monArm | output | 1 | Set the local monitor to exclusive |
| monAddr | output | 32 | Address recorded in the local monitor |
| monSize | output | 4 | Access size recorded, in bytes (8) |
| globalMark | output | 1 | Mark request to the global monitor |
| globalMarkAddr | output | 32 | Address to mark |
| alignFault | output | 1 | Misaligned address pulse |

## Verification
The hardest situation to reach is a second request arriving while a read is stalled by memory backpressure. That request must not disturb the pending address or produce a second read. The directed load task holds `memReqReady` low for several cycles and presents a different base during that stall, then counts read handshakes, monitor arms and marks. A second hard case is a failed condition combined with a misaligned address, which has to stay silent rather than raise a fault. The skip scenario drives that combination on purpose.

// File: rtl/ldxPairPkg.sv
package ldxPairPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_DONE,
    ST_FAULT
  } ldxState_e;

  typedef struct packed {
    logic latchReq;
    logic captureRsp;
  } ldxStrobe_t;

endpackage

// File: rtl/ldxPairCtrl.sv
module ldxPairCtrl
  import ldxPairPkg::*;
#(
  parameter int ALIGN_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqCondPass,
  input  logic [ALIGN_BITS-1:0] reqBaseLow,
  input  logic                  sharedLatched,
  input  logic                  memReqReady,
  input  logic                  memRspValid,
  output logic                  reqReady,
  output logic                  memReqValid,
  output logic                  monArm,
  output logic                  globalMark,
  output logic                  wbValid,
  output logic                  alignFault,
  output ldxStrobe_t            strb
);

  ldxState_e state, stateNext;
  logic accept;
  logic misaligned;

  assign accept     = reqValid && (state == ST_IDLE);
  assign misaligned = (reqBaseLow != '0);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept && reqCondPass) stateNext = misaligned ? ST_FAULT : ST_READ;
      ST_READ:  if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady        = (state == ST_IDLE);
  assign memReqValid     = (state == ST_READ);
  assign monArm          = memReqValid && memReqReady;
  assign globalMark      = monArm && sharedLatched;
  assign wbValid         = (state == ST_DONE);
  assign alignFault      = (state == ST_FAULT);
  assign strb.latchReq   = accept && reqCondPass && !misaligned;
  assign strb.captureRsp = (state == ST_WAIT) && memRspValid;

  // R2: a pending read is held until memory takes it
  assert_read_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  // R2: exactly one read, request drops after handshake
  assert_read_once_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);

  // R10: done is a single pulse following a response
  assert_wb_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid);
  assert_wb_after_rsp_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbValid) |-> $past(memRspValid));

  // R8: fault is one cycle and never accompanies a read
  assert_fault_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |=> !alignFault && !memReqValid);

  // R7: a skipped request leaves the unit idle
  assert_skip_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !reqCondPass |=> reqReady && !memReqValid && !alignFault);

  // R6: a mark only ever comes with a local arm
  assert_mark_with_arm_R6: assert property (@(posedge clk) disable iff (!rstN)
    globalMark |-> monArm && memReqValid);

endmodule

// File: rtl/ldxPairDatapath.sv
module ldxPairDatapath
  import ldxPairPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32,
  parameter int IDX_W  = 4,
  localparam int DATA_W = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldxStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [IDX_W-1:0]  reqDstA,
  input  logic [IDX_W-1:0]  reqDstB,
  input  logic              reqBigEndian,
  input  logic              reqShared,
  input  logic [DATA_W-1:0] memRspData,
  output logic [ADDR_W-1:0] addrQ,
  output logic              sharedQ,
  output logic [IDX_W-1:0]  wbIdxA,
  output logic [REG_W-1:0]  wbDataA,
  output logic [IDX_W-1:0]  wbIdxB,
  output logic [REG_W-1:0]  wbDataB
);

  logic              bigQ;
  logic [REG_W-1:0]  lowHalf, highHalf;

  assign lowHalf  = memRspData[REG_W-1:0];
  assign highHalf = memRspData[DATA_W-1:REG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      sharedQ <= 1'b0;
      bigQ    <= 1'b0;
      wbIdxA  <= '0;
      wbIdxB  <= '0;
    end else if (strb.latchReq) begin
      addrQ   <= reqBase;
      sharedQ <= reqShared;
      bigQ    <= reqBigEndian;
      wbIdxA  <= reqDstA;
      wbIdxB  <= reqDstB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbDataA <= '0;
      wbDataB <= '0;
    end else if (strb.captureRsp) begin
      wbDataA <= bigQ ? highHalf : lowHalf;
      wbDataB <= bigQ ? lowHalf : highHalf;
    end
  end

  // R1: the recorded address only moves when a new request is latched
  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchReq |=> $stable(addrQ));

  // R9: destination indices do not change without a new latch
  assert_idx_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchReq |=> $stable(wbIdxA) && $stable(wbIdxB));

endmodule

// File: rtl/ldxPairUnit.sv
module ldxPairUnit
  import ldxPairPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32,
  parameter int IDX_W  = 4,
  localparam int DATA_W     = 2 * REG_W,
  localparam int ACC_BYTES  = DATA_W / 8,
  localparam int ALIGN_BITS = $clog2(ACC_BYTES),
  localparam int SIZE_W     = ALIGN_BITS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [IDX_W-1:0]  reqDstA,
  input  logic [IDX_W-1:0]  reqDstB,
  input  logic              reqCondPass,
  input  logic              reqBigEndian,
  input  logic              reqShared,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              wbValid,
  output logic [IDX_W-1:0]  wbIdxA,
  output logic [REG_W-1:0]  wbDataA,
  output logic [IDX_W-1:0]  wbIdxB,
  output logic [REG_W-1:0]  wbDataB,
  output logic              monArm,
  output logic [ADDR_W-1:0] monAddr,
  output logic [SIZE_W-1:0] monSize,
  output logic              globalMark,
  output logic [ADDR_W-1:0] globalMarkAddr,
  output logic              alignFault
);

  ldxStrobe_t        strb;
  logic [ADDR_W-1:0] addrQ;
  logic              sharedQ;

  ldxPairCtrl #(.ALIGN_BITS(ALIGN_BITS)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqCondPass  (reqCondPass),
    .reqBaseLow   (reqBase[ALIGN_BITS-1:0]),
    .sharedLatched(sharedQ),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .monArm       (monArm),
    .globalMark   (globalMark),
    .wbValid      (wbValid),
    .alignFault   (alignFault),
    .strb         (strb)
  );

  ldxPairDatapath #(.ADDR_W(ADDR_W), .REG_W(REG_W), .IDX_W(IDX_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqBase     (reqBase),
    .reqDstA     (reqDstA),
    .reqDstB     (reqDstB),
    .reqBigEndian(reqBigEndian),
    .reqShared   (reqShared),
    .memRspData  (memRspData),
    .addrQ       (addrQ),
    .sharedQ     (sharedQ),
    .wbIdxA      (wbIdxA),
    .wbDataA     (wbDataA),
    .wbIdxB      (wbIdxB),
    .wbDataB     (wbDataB)
  );

  assign memReqAddr     = addrQ;
  assign monAddr        = addrQ;
  assign globalMarkAddr = addrQ;
  assign monSize        = SIZE_W'(ACC_BYTES);

endmodule

// File: tb/test_ldxPairUnit.sv
module test_ldxPairUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqBase = '0;
  logic [3:0]  reqDstA = '0;
  logic [3:0]  reqDstB = '0;
  logic        reqCondPass = 1'b0;
  logic        reqBigEndian = 1'b0;
  logic        reqShared = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        wbValid;
  logic [3:0]  wbIdxA, wbIdxB;
  logic [31:0] wbDataA, wbDataB;
  logic        monArm;
  logic [31:0] monAddr;
  logic [3:0]  monSize;
  logic        globalMark;
  logic [31:0] globalMarkAddr;
  logic        alignFault;

  always #10 clk = ~clk;

  ldxPairUnit i_ldxPairUnit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBase(reqBase), .reqDstA(reqDstA), .reqDstB(reqDstB),
    .reqCondPass(reqCondPass), .reqBigEndian(reqBigEndian), .reqShared(reqShared),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .wbValid(wbValid), .wbIdxA(wbIdxA), .wbDataA(wbDataA),
    .wbIdxB(wbIdxB), .wbDataB(wbDataB),
    .monArm(monArm), .monAddr(monAddr), .monSize(monSize),
    .globalMark(globalMark), .globalMarkAddr(globalMarkAddr),
    .alignFault(alignFault)
  );

  int testCount = 0;
  int failCount = 0;
  int nRead = 0, nArm = 0, nGlob = 0, nWb = 0, nFault = 0;
  logic [31:0] lastMonAddr = '0, lastGlobAddr = '0;
  logic [3:0]  lastMonSize = '0;

  // event counters, sampled mid-cycle
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (memReqValid && memReqReady) nRead++;
      if (monArm) begin nArm++; lastMonAddr = monAddr; lastMonSize = monSize; end
      if (globalMark) begin nGlob++; lastGlobAddr = globalMarkAddr; end
      if (wbValid) nWb++;
      if (alignFault) nFault++;
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    check("R9", "reqReady after reset", reqReady, 1);
    check("R2", "memReqValid after reset", memReqValid, 0);
    check("R10", "wbValid after reset", wbValid, 0);
    check("R5", "monArm after reset", monArm, 0);
    check("R8", "alignFault after reset", alignFault, 0);
  endtask

  task automatic doLoad(input logic [31:0] base, input logic [3:0] ia, input logic [3:0] ib,
                        input bit big, input bit sh, input logic [63:0] data,
                        input int delay, input bit busy);
    int preRead = nRead, preArm = nArm, preGlob = nGlob, preWb = nWb;
    logic [31:0] expA = big ? data[63:32] : data[31:0];
    logic [31:0] expB = big ? data[31:0] : data[63:32];
    string endTag = big ? "R4" : "R3";
    @(negedge clk);
    reqValid = 1; reqBase = base; reqDstA = ia; reqDstB = ib;
    reqCondPass = 1; reqBigEndian = big; reqShared = sh;
    #1 check("R9", "ready while idle", reqReady, 1);
    @(negedge clk);
    reqValid = 0;
    if (busy) begin
      reqValid = 1; reqBase = base ^ 32'h0000_0100; reqShared = ~sh;
      reqBigEndian = ~big; reqDstA = ~ia;
    end
    #1;
    check("R2", "read requested", memReqValid, 1);
    check("R1", "read address", memReqAddr, base);
    for (int k = 0; k < delay; k++) begin
      @(negedge clk); #1;
      check("R2", "read held under stall", memReqValid, 1);
      check("R9", "busy not ready", reqReady, 0);
      check("R1", "address stable", memReqAddr, base);
    end
    @(negedge clk);
    reqValid = 0; memReqReady = 1;
    #1 check("R5", "arm in handshake", monArm, 1);
    @(negedge clk);
    memReqReady = 0; memRspValid = 1; memRspData = data;
    #1;
    check("R2", "read dropped after handshake", memReqValid, 0);
    check("R10", "no early done", wbValid, 0);
    @(negedge clk);
    memRspValid = 0; memRspData = ~data;
    #1;
    check("R10", "done one cycle after response", wbValid, 1);
    check(endTag, "index A", wbIdxA, ia);
    check(endTag, "data A", wbDataA, expA);
    check(endTag, "index B", wbIdxB, ib);
    check(endTag, "data B", wbDataB, expB);
    @(negedge clk); #3;
    check("R10", "done is a single pulse", wbValid, 0);
    check("R9", "idle again", reqReady, 1);
    check("R2", "one read", nRead, preRead + 1);
    check("R10", "one done", nWb, preWb + 1);
    check("R5", "one arm", nArm, preArm + 1);
    check("R5", "arm address", lastMonAddr, base);
    check("R5", "arm size 8", lastMonSize, 8);
    check("R6", "global mark count", nGlob, preGlob + (sh ? 1 : 0));
    if (sh) check("R6", "global mark address", lastGlobAddr, base);
  endtask

  task automatic testSkip(input logic [31:0] base);
    int preRead = nRead, preArm = nArm, preGlob = nGlob, preWb = nWb, preFault = nFault;
    @(negedge clk);
    reqValid = 1; reqBase = base; reqCondPass = 0; reqShared = 1;
    #1 check("R7", "ready for skipped request", reqReady, 1);
    @(negedge clk);
    reqValid = 0;
    #1;
    check("R7", "ready next cycle", reqReady, 1);
    check("R7", "no read", memReqValid, 0);
    repeat (3) begin
      @(negedge clk); #1;
      check("R7", "still no read", memReqValid, 0);
    end
    #2;
    check("R7", "read count", nRead, preRead);
    check("R7", "arm count", nArm, preArm);
    check("R7", "mark count", nGlob, preGlob);
    check("R7", "done count", nWb, preWb);
    check("R7", "fault count", nFault, preFault);
  endtask

  task automatic testFault(input logic [31:0] base);
    int preRead = nRead, preArm = nArm, preWb = nWb, preFault = nFault;
    @(negedge clk);
    reqValid = 1; reqBase = base; reqCondPass = 1; reqShared = 1;
    @(negedge clk);
    reqValid = 0;
    #1;
    check("R8", "fault raised", alignFault, 1);
    check("R8", "no read on fault", memReqValid, 0);
    @(negedge clk); #3;
    check("R8", "fault one cycle", alignFault, 0);
    check("R9", "idle after fault", reqReady, 1);
    check("R8", "fault count", nFault, preFault + 1);
    check("R8", "no read", nRead, preRead);
    check("R8", "no arm", nArm, preArm);
    check("R8", "no done", nWb, preWb);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    testReset();
    doLoad(32'h0000_1000, 4'd2, 4'd3, 0, 0, 64'h8899_AABB_1122_3344, 0, 0);
    doLoad(32'h2000_0A08, 4'd4, 4'd7, 1, 1, 64'hDEAD_BEEF_0123_4567, 3, 1);
    doLoad(32'hFFFF_FFF8, 4'd0, 4'd1, 0, 1, 64'h0, 1, 0);
    doLoad(32'h0000_0040, 4'd10, 4'd11, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    testSkip(32'h0000_3000);
    testSkip(32'h0000_3005);
    testFault(32'h0000_1004);
    testFault(32'h0000_1001);
    doLoad(32'h0000_5008, 4'd8, 4'd9, 0, 1, 64'h7654_3210_FEDC_BA98, 2, 1);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule